// File: doc/BRIEF.md
# Boundary Scan Pad Chain

This block sits between the peripheral logic of a chip and its pads. Every pin has three live signals: a value from the pad toward the core, a value from the core toward the pad, and an output-enable from the core toward the pad. Each signal passes through its own scan cell. A cell holds one stage of a serial shift register, one update register and a selector. In normal operation the selectors are transparent, so the core and the pads talk directly. A test access controller drives the block. It asserts a capture strobe to load all live values into the shift stages at once. It asserts a shift strobe to move the captured data toward the serial output while new data enters from the serial input. It asserts an update strobe to copy the shift stages into the update registers. In the external-test mode the update registers replace the live values on both sides of the pin.

The serial path runs from the serial input through pin 0, then pin 1, and so on. Within a pin it visits the input cell, then the output cell, then the output-enable cell. The last pin's output-enable stage drives the serial output. The chain length is three times the pin count.

Top module: `bsc_pad_chain`

## Requirements
- R1: Reset is active low and asynchronous. Its release takes effect at the second rising clock edge after `rst_n` rises. Reset clears every shift stage and every update register, so `tdo` reads 0, and entering external-test mode without an update drives 0 on `core_i`, `pad_o` and `pad_oe`.
- R2: With `test_mode` 2'b00 (normal) or 2'b11 (spare, treated as normal), `pad_o` equals `core_o`, `pad_oe` equals `core_oe` and `core_i` equals `pad_i` in the same cycle, bit for bit.
- R3: With `test_mode` 2'b01 (sample), the live signals pass through exactly as in R2, whatever is shifted, captured or updated.
- R4: With `test_mode` 2'b10 (external test), `core_i`, `pad_o` and `pad_oe` take the update registers of the pins' input, output and output-enable cells, and the live values `pad_i`, `core_o` and `core_oe` have no effect on them.
- R5: At a rising edge with `cap_en` high, every shift stage loads in parallel: the input cells load `pad_i`, the output cells load `core_o` and the output-enable cells load `core_oe`. Capture wins over a shift in the same cycle. Capture happens in every mode.
- R6: At a rising edge with `shift_en` high and `cap_en` low, data moves one stage toward `tdo`, and `tdi` enters the stage of pin 0's input cell. Stage index 3p+k holds pin p, cell k (k=0 input, k=1 output, k=2 output-enable). `tdo` is stage 3N-1, so after a capture `tdo` presents pin N-1's output-enable, then its output, then its input, and so on. With both strobes low, the stages hold.
- R7: While `shift_en` is held high, the bit on `tdi` at one clock edge appears on `tdo` before the edge 3N cycles later. This holds for all-ones, all-zeros and mixed patterns.
- R8: The update registers change only at an edge where `upd_en` is high, when each one copies its own shift stage. In external-test mode the pin outputs therefore stay stable while data is shifting and change in the cycle after the update edge.
- R9: After all ones are shifted in and updated in external-test mode, `core_i`, `pad_o` and `pad_oe` are all high. A capture in that state still records undriven pads (`pad_i` low) as 0 in the input cells.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 2 | 00 normal, 01 sample, 10 external test, 11 normal |
| cap_en | input | 1 | Parallel capture strobe |
| shift_en | input | 1 | Serial shift strobe |
| upd_en | input | 1 | Update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (last stage) |
| core_o | input | NUM_PINS | Core output values |
| core_oe | input | NUM_PINS | Core output-enables |
| core_i | output | NUM_PINS | Input values delivered to the core |
| pad_i | input | NUM_PINS | Values arriving from the pads |
| pad_o | output | NUM_PINS | Output values driven to the pads |
| pad_oe | output | NUM_PINS | Output-enables driven to the pads |

## Verification
A shift stage with a wrong value stays hidden until it reaches `tdo`. The delay is the number of stages between that cell and the end of the chain, so a fault in pin 0's input cell only shows on the last bit of a full read. A wrong update register shows on the pin outputs in the cycle after the update edge, and only in external-test mode. In the other modes it stays invisible until the mode changes, so every update is read back at the pins while the chain is in external-test mode. A selector fault shows in the same cycle as the mode change, because the pass-through path has no register in it.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_SAMPLE = 2'b01,
    MODE_EXTEST = 2'b10,
    MODE_SPARE  = 2'b11
  } bs_mode_e;

  localparam int CELLS_PER_PIN = 3;
  localparam int CELL_IN  = 0;
  localparam int CELL_OUT = 1;
  localparam int CELL_OE  = 2;
endpackage

// File: rtl/bsc_rst_sync.sv
module bsc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/bsc_cell.sv
module bsc_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic test_sel,
  input  logic func_in,
  input  logic ser_in,
  output logic ser_out,
  output logic mux_out
);
  logic sr_q, sr_d;
  logic upd_q, upd_d;

  // shift stage: capture has priority over shift
  always_comb begin
    sr_d = sr_q;
    if (cap_en) begin
      sr_d = func_in;
    end else if (shift_en) begin
      sr_d = ser_in;
    end
  end

  // update stage: loads only on the update strobe
  always_comb begin
    upd_d = upd_q;
    if (upd_en) begin
      upd_d = sr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      sr_q  <= sr_d;
      upd_q <= upd_d;
    end
  end

  assign ser_out = sr_q;
  assign mux_out = test_sel ? upd_q : func_in;

  // R5
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_en |=> (ser_out == $past(func_in)));

  // R6
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cap_en) |=> (ser_out == $past(ser_in)));

  // R4 R8
  extest_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel && upd_en) ##1 test_sel |-> (mux_out == $past(ser_out)));
endmodule

// File: rtl/bsc_pad.sv
module bsc_pad
  import bsc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic test_sel,
  input  logic pin_pad_i,
  input  logic pin_core_o,
  input  logic pin_core_oe,
  input  logic ser_in,
  output logic ser_out,
  output logic pin_core_i,
  output logic pin_pad_o,
  output logic pin_pad_oe
);
  logic [CELLS_PER_PIN-1:0] func_w;
  logic [CELLS_PER_PIN-1:0] mux_w;
  logic [CELLS_PER_PIN:0]   link_w;

  assign func_w[CELL_IN]  = pin_pad_i;
  assign func_w[CELL_OUT] = pin_core_o;
  assign func_w[CELL_OE]  = pin_core_oe;
  assign link_w[0]        = ser_in;

  for (genvar k = 0; k < CELLS_PER_PIN; k++) begin : g_cell
    bsc_cell u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_en   (cap_en),
      .shift_en (shift_en),
      .upd_en   (upd_en),
      .test_sel (test_sel),
      .func_in  (func_w[k]),
      .ser_in   (link_w[k]),
      .ser_out  (link_w[k+1]),
      .mux_out  (mux_w[k])
    );
  end

  assign ser_out    = link_w[CELLS_PER_PIN];
  assign pin_core_i = mux_w[CELL_IN];
  assign pin_pad_o  = mux_w[CELL_OUT];
  assign pin_pad_oe = mux_w[CELL_OE];
endmodule

// File: rtl/bsc_pad_chain.sv
module bsc_pad_chain
  import bsc_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          test_mode,
  input  logic                cap_en,
  input  logic                shift_en,
  input  logic                upd_en,
  input  logic                tdi,
  output logic                tdo,
  input  logic [NUM_PINS-1:0] core_o,
  input  logic [NUM_PINS-1:0] core_oe,
  output logic [NUM_PINS-1:0] core_i,
  input  logic [NUM_PINS-1:0] pad_i,
  output logic [NUM_PINS-1:0] pad_o,
  output logic [NUM_PINS-1:0] pad_oe
);
  localparam int CHAIN_LEN = NUM_PINS * CELLS_PER_PIN;

  logic           rst_int_n;
  bs_mode_e       mode_w;
  logic           ext_sel;
  logic [NUM_PINS:0] pin_link;

  bsc_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  assign mode_w      = bs_mode_e'(test_mode);
  assign ext_sel     = (mode_w == MODE_EXTEST);
  assign pin_link[0] = tdi;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    bsc_pad u_pad (
      .clk         (clk),
      .rst_n       (rst_int_n),
      .cap_en      (cap_en),
      .shift_en    (shift_en),
      .upd_en      (upd_en),
      .test_sel    (ext_sel),
      .pin_pad_i   (pad_i[p]),
      .pin_core_o  (core_o[p]),
      .pin_core_oe (core_oe[p]),
      .ser_in      (pin_link[p]),
      .ser_out     (pin_link[p+1]),
      .pin_core_i  (core_i[p]),
      .pin_pad_o   (pad_o[p]),
      .pin_pad_oe  (pad_oe[p])
    );
  end

  assign tdo = pin_link[NUM_PINS];

  // R2
  normal_pass_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_w == MODE_NORMAL || mode_w == MODE_SPARE) |->
      (core_i == pad_i && pad_o == core_o && pad_oe == core_oe));

  // R3
  sample_live_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_w == MODE_SAMPLE) |->
      (core_i == pad_i && pad_o == core_o && pad_oe == core_oe));

  // R8
  extest_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ext_sel && !upd_en) |=>
      (!ext_sel || ($stable(pad_o) && $stable(pad_oe) && $stable(core_i))));

  // R6
  chain_len_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (shift_en && !cap_en && CHAIN_LEN > 0) |=> (tdo == $past(g_pin[NUM_PINS-1].u_pad.link_w[CELLS_PER_PIN-1])));
endmodule

// File: tb/sim_bsc_pad_chain.sv
module sim_bsc_pad_chain;
  localparam int NP = 4;
  localparam int L  = 3 * NP;

  logic          clk;
  logic          rst_n;
  logic [1:0]    test_mode;
  logic          cap_en, shift_en, upd_en, tdi;
  logic          tdo;
  logic [NP-1:0] core_o, core_oe, core_i, pad_i, pad_o, pad_oe;

  int n_chk;
  int n_fail;
  bit done;

  bsc_pad_chain #(.NUM_PINS(NP)) u0 (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode),
    .cap_en(cap_en), .shift_en(shift_en), .upd_en(upd_en),
    .tdi(tdi), .tdo(tdo),
    .core_o(core_o), .core_oe(core_oe), .core_i(core_i),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic [1:0]    mode;
    logic [NP-1:0] co;
    logic [NP-1:0] coe;
    logic [NP-1:0] pi;
    logic [NP-1:0] e_ci;
    logic [NP-1:0] e_po;
    logic [NP-1:0] e_poe;
  } vec_t;

  // table is walked while every update register holds 1
  localparam vec_t TBL [7] = '{
    '{2'b00, 4'hA, 4'h3, 4'h5, 4'h5, 4'hA, 4'h3},
    '{2'b00, 4'h0, 4'hF, 4'hC, 4'hC, 4'h0, 4'hF},
    '{2'b01, 4'h6, 4'h9, 4'h1, 4'h1, 4'h6, 4'h9},
    '{2'b01, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
    '{2'b11, 4'h3, 4'h8, 4'hE, 4'hE, 4'h3, 4'h8},
    '{2'b10, 4'h0, 4'h0, 4'h0, 4'hF, 4'hF, 4'hF},
    '{2'b10, 4'h5, 4'hA, 4'h9, 4'hF, 4'hF, 4'hF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [L-1:0] mk(input logic [NP-1:0] iv, input logic [NP-1:0] ov,
                                      input logic [NP-1:0] ev);
    logic [L-1:0] v;
    for (int p = 0; p < NP; p++) begin
      v[3*p]   = iv[p];
      v[3*p+1] = ov[p];
      v[3*p+2] = ev[p];
    end
    return v;
  endfunction

  // full read-and-replace; vectors are indexed by stage
  task automatic shift_word(input logic [L-1:0] din, output logic [L-1:0] old);
    for (int i = 0; i < L; i++) begin
      tdi      = din[L-1-i];
      shift_en = 1'b1;
      #1;
      old[L-1-i] = tdo;
      tick();
    end
    shift_en = 1'b0;
    tdi      = 1'b0;
  endtask

  task automatic pulse_cap();
    cap_en = 1'b1;
    tick();
    cap_en = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_en = 1'b1;
    tick();
    upd_en = 1'b0;
  endtask

  function automatic logic sbit(input int j);
    if (j < L) return 1'b1;
    if (j < 2 * L) return 1'b0;
    return logic'(((j * 7) >> 1) & 1);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [L-1:0] rd;
    logic [NP-1:0] held;
    logic          tdo0;
    int            miss;
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; test_mode = 2'b00;
    cap_en = 1'b0; shift_en = 1'b0; upd_en = 1'b0; tdi = 1'b0;
    core_o = 4'h9; core_oe = 4'h5; pad_i = 4'h3;
    repeat (3) tick();

    // R1 reset state
    chk("R1 tdo in reset", tdo, 1'b0);
    chk("R2 pad_o in reset", pad_o, 4'h9);
    chk("R2 core_i in reset", core_i, 4'h3);
    rst_n = 1'b1;
    repeat (3) tick();
    test_mode = 2'b10;
    core_o = 4'hF; core_oe = 4'hF; pad_i = 4'hF;
    #1;
    chk("R1 extest before update pad_o", pad_o, 4'h0);
    chk("R1 extest before update pad_oe", pad_oe, 4'h0);
    chk("R1 extest before update core_i", core_i, 4'h0);

    // R5 capture in sample mode, R6 order toward tdo
    test_mode = 2'b01;
    core_o = 4'b1010; core_oe = 4'b0110; pad_i = 4'b0011;
    pulse_cap();
    chk("R6 first tdo is last pin oe", tdo, core_oe[NP-1]);
    shift_word('0, rd);
    chk("R5 capture read", rd, mk(4'b0011, 4'b1010, 4'b0110));
    chk("R3 sample live after shift", core_i, 4'b0011);

    // R5 capture wins over shift
    core_o = 4'b0101; core_oe = 4'b1001; pad_i = 4'b1110;
    cap_en = 1'b1; shift_en = 1'b1; tdi = 1'b1;
    tick();
    cap_en = 1'b0; shift_en = 1'b0; tdi = 1'b0;
    // R6 hold with both strobes low
    tdo0 = tdo;
    for (int i = 0; i < 3; i++) begin
      tdi = ~tdi;
      tick();
    end
    chk("R6 hold without shift", tdo, tdo0);
    shift_word('0, rd);
    chk("R5 capture priority read", rd, mk(4'b1110, 4'b0101, 4'b1001));

    // R4 R8 external test drive
    test_mode = 2'b10;
    shift_word(mk(4'b1001, 4'b0101, 4'b1100), rd);
    chk("R8 no update yet pad_o", pad_o, 4'h0);
    pulse_upd();
    chk("R4 pad_o from update", pad_o, 4'b0101);
    chk("R4 pad_oe from update", pad_oe, 4'b1100);
    chk("R4 core_i from update", core_i, 4'b1001);
    core_o = 4'hF; core_oe = 4'h0; pad_i = 4'h6;
    #1;
    chk("R4 live ignored pad_o", pad_o, 4'b0101);
    chk("R4 live ignored core_i", core_i, 4'b1001);
    held = pad_oe;
    shift_word(mk(4'h6, 4'h6, 4'h6), rd);
    chk("R8 stable during shift pad_oe", pad_oe, held);
    chk("R8 stable during shift pad_o", pad_o, 4'b0101);
    test_mode = 2'b01;
    #1;
    chk("R3 sample restores live", pad_o, 4'hF);

    // R9 all ones in external test
    test_mode = 2'b10;
    shift_word('1, rd);
    pulse_upd();
    chk("R9 core_i all high", core_i, 4'hF);
    chk("R9 pad_o all high", pad_o, 4'hF);
    chk("R9 pad_oe all high", pad_oe, 4'hF);
    pad_i = 4'h0; core_o = 4'h6; core_oe = 4'h9;
    pulse_cap();
    shift_word('1, rd);
    chk("R9 undriven pads read low", rd, mk(4'h0, 4'h6, 4'h9));

    // R2 R3 R4 table walk
    for (int r = 0; r < 7; r++) begin
      test_mode = TBL[r].mode;
      core_o = TBL[r].co; core_oe = TBL[r].coe; pad_i = TBL[r].pi;
      #1;
      chk($sformatf("R2 R3 R4 row %0d core_i", r), core_i, TBL[r].e_ci);
      chk($sformatf("R2 R3 R4 row %0d pad_o", r), pad_o, TBL[r].e_po);
      chk($sformatf("R2 R3 R4 row %0d pad_oe", r), pad_oe, TBL[r].e_poe);
      tick();
    end

    // R7 tdi to tdo delay with shift held
    miss = 0;
    shift_en = 1'b1;
    for (int j = 0; j < 4 * L; j++) begin
      tdi = sbit(j);
      #1;
      if (j >= L && tdo !== sbit(j - L)) miss++;
      tick();
    end
    shift_en = 1'b0;
    chk("R7 delay mismatches", miss, 0);

    finish_run();
  end
endmodule